// File: doc/BRIEF.md
# NRZI Line Decoder with Bit Unstuffing

This block sits behind a line sampler on a serial bus whose two wires carry differential J and K states plus the single-ended states SE0 and SE1. Each accepted symbol arrives with a one-cycle valid strobe. A start-of-packet pulse from the sampler arms the decoder. The decoder turns NRZI line states into data bits: when the state stays the same the bit is a one, and when it toggles the bit is a zero. It removes the zero that the transmitter forces in after a run of ones. It flags a run that is too long. It recognises the SE0-then-J sequence that closes a packet.

Every result is a single-cycle registered strobe that appears on the clock edge after the symbol that caused it. Downstream logic assembles bytes from the bit strobe. It uses the end-of-packet strobe to close the frame and the error strobe to discard it. Symbol codes are J = 2'b01, K = 2'b10, SE0 = 2'b00 and SE1 = 2'b11. The run limit `RUN_LEN` defaults to six.

Top module: `nrzi_unstuff`

## Requirements
- R1: In a packet, a J or K symbol equal to the previous line state yields `bit_valid` with `bit_data`=1, and a J or K symbol that differs yields `bit_data`=0. The strobe appears one clock after the symbol is accepted.
- R2: A `sop` pulse puts the decoder in the packet state, sets the previous line state to J, clears the ones count and clears the error lock. Before the first `sop`, or after a packet has ended, `sym_valid` is ignored and no strobe results.
- R3: The next J/K symbol after `RUN_LEN` decoded ones may decode as 0. If it does, it is dropped: `stuff_drop` pulses, no `bit_valid` is given, and the ones count restarts from zero.
- R4: The next J/K symbol after `RUN_LEN` decoded ones may decode as 1. If it does, `stuff_err` pulses and no `bit_valid` is given.
- R5: After a stuff error, no `bit_valid`, `stuff_drop` or further `stuff_err` is produced until the next `sop`. End-of-packet detection still works.
- R6: An SE0 symbol in a packet starts end-of-packet handling. SE0, SE1 and the closing J produce no data bit. An SE1 in the data phase is ignored and leaves the previous line state unchanged.
- R7: One or more SE0 symbols followed by a J give a single `eop` pulse and return the decoder to idle. In that phase, K and SE1 are ignored.
- R8: All strobes last exactly one cycle, at most one of them is high in any cycle, and none rises without an accepted symbol.
- R9: When `sop` and `sym_valid` are high in the same cycle, `sop` wins and the symbol is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sop | input | 1 | Start-of-packet pulse that arms the decoder |
| sym_valid | input | 1 | Symbol strobe |
| sym | input | 2 | Line symbol: 00 SE0, 01 J, 10 K, 11 SE1 |
| bit_valid | output | 1 | Decoded data bit strobe |
| bit_data | output | 1 | Decoded data bit value |
| stuff_drop | output | 1 | A stuff bit was removed |
| stuff_err | output | 1 | Bit-stuffing violation |
| eop | output | 1 | End of packet seen |

## Verification
The decoder keeps four pieces of hidden state: the previous line state, the ones count, the error lock and the phase. A wrong value in any of them shows at the ports on the next J/K symbol:
- a wrong previous line state inverts `bit_data` at once;
- a wrong ones count moves the stuff drop or the error earlier or later within at most `RUN_LEN` symbols;
- a stuck lock or phase drops or adds bits until the next `sop`.

Each of the 1024 ten-bit patterns is encoded with NRZI and bit stuffing in the bench and decoded back. Every run length around the limit is therefore seen, and so is every toggle pattern.

// File: rtl/nrzi_unstuff.sv
module nrzi_unstuff #(
  parameter int RUN_LEN = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sop,
  input  logic       sym_valid,
  input  logic [1:0] sym,
  output logic       bit_valid,
  output logic       bit_data,
  output logic       stuff_drop,
  output logic       stuff_err,
  output logic       eop
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [1:0] L_SE0 = 2'b00;
  localparam logic [1:0] L_J   = 2'b01;
  localparam logic [1:0] L_K   = 2'b10;

  typedef enum logic [1:0] {PH_IDLE, PH_DATA, PH_TAIL} phase_t;

  phase_t        phase;
  logic [1:0]    prev;
  logic [CW-1:0] ones;
  logic          locked;

  wire is_line  = (sym == L_J) || (sym == L_K);
  wire same     = (sym == prev);
  wire at_limit = (ones == CW'(RUN_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      prev       <= L_J;
      ones       <= '0;
      locked     <= 1'b0;
      bit_valid  <= 1'b0;
      bit_data   <= 1'b0;
      stuff_drop <= 1'b0;
      stuff_err  <= 1'b0;
      eop        <= 1'b0;
    end else begin
      bit_valid  <= 1'b0;
      stuff_drop <= 1'b0;
      stuff_err  <= 1'b0;
      eop        <= 1'b0;
      if (sop) begin
        phase  <= PH_DATA;
        prev   <= L_J;
        ones   <= '0;
        locked <= 1'b0;
      end else if (sym_valid) begin
        case (phase)
          PH_DATA: begin
            if (sym == L_SE0) begin
              phase <= PH_TAIL;
            end else if (is_line) begin
              prev <= sym;
              if (!locked) begin
                if (at_limit) begin
                  if (!same) begin
                    stuff_drop <= 1'b1;
                    ones       <= '0;
                  end else begin
                    stuff_err <= 1'b1;
                    locked    <= 1'b1;
                  end
                end else begin
                  bit_valid <= 1'b1;
                  bit_data  <= same;
                  ones      <= same ? ones + 1'b1 : '0;
                end
              end
            end
          end
          PH_TAIL: begin
            if (sym == L_J) begin
              eop   <= 1'b1;
              phase <= PH_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/nrzi_unstuff_chk.sv
module nrzi_unstuff_chk #(
  parameter int RUN_LEN = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sop,
  input logic       sym_valid,
  input logic [1:0] sym,
  input logic       bit_valid,
  input logic       bit_data,
  input logic       stuff_drop,
  input logic       stuff_err,
  input logic       eop
);
  localparam int LIMIT = RUN_LEN;

  wire any_strobe = bit_valid | stuff_drop | stuff_err | eop;

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bit_valid, stuff_drop, stuff_err, eop}));

  a_r9_needs_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |-> $past(sym_valid && !sop));

  a_r6_bit_from_line: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid || stuff_drop || stuff_err) |-> $past(sym == 2'b01 || sym == 2'b10));

  a_r7_eop_on_j: assert property (@(posedge clk) disable iff (!rst_n)
    eop |-> $past(sym) == 2'b01);

  a_r7_eop_then_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    eop |=> !(bit_valid || stuff_drop || stuff_err || eop));

  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (eop || stuff_err) |=> !(eop || stuff_err));

  initial assert (LIMIT > 0);
endmodule

bind nrzi_unstuff nrzi_unstuff_chk #(.RUN_LEN(RUN_LEN)) chk_i (.*);

// File: tb/nrzi_unstuff_tb.sv
module nrzi_unstuff_tb_top;
  localparam int PERIOD = 10;
  localparam logic [1:0] S0 = 2'b00, SJ = 2'b01, SK = 2'b10, S1 = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0, sop = 1'b0, sym_valid = 1'b0;
  logic [1:0] sym = SJ;
  logic bit_valid, bit_data, stuff_drop, stuff_err, eop;

  nrzi_unstuff #(.RUN_LEN(6)) dut_i (.*);

  always #(PERIOD/2) clk = ~clk;

  int total = 0, fails = 0;
  int nb, n_drop, n_err, n_eop, n_gap;
  logic [31:0] word;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    nb = 0; n_drop = 0; n_err = 0; n_eop = 0; n_gap = 0; word = '0;
  endtask

  task automatic grab();
    if (bit_valid) begin word = {word[30:0], bit_data}; nb++; end
    if (stuff_drop) n_drop++;
    if (stuff_err) n_err++;
    if (eop) n_eop++;
  endtask

  task automatic gap();
    @(negedge clk); sop = 1'b0; sym_valid = 1'b0;
    @(posedge clk); #1;
    if (bit_valid | stuff_drop | stuff_err | eop) n_gap++;
  endtask

  task automatic put(input logic [1:0] s);
    @(negedge clk); sym_valid = 1'b1; sym = s;
    @(posedge clk); #1; grab();
    gap();
  endtask

  task automatic start();
    @(negedge clk); sop = 1'b1;
    @(posedge clk); #1; grab();
    gap();
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [1:0] line;
    int ones, nst;
    repeat (3) @(posedge clk);
    #1;
    chk({bit_valid, stuff_drop, stuff_err, eop} == 0, "R8 reset outputs", int'({bit_valid, stuff_drop, stuff_err, eop}), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: idle ignores symbols
    clr(); put(SK); put(SJ); put(S0); put(SJ);
    chk(nb + n_drop + n_err + n_eop == 0, "R2 idle ignores symbols", nb + n_drop + n_err + n_eop, 0);

    // R1 R3 R7: encode every 10-bit pattern, decode back
    for (int p = 0; p < 1024; p++) begin
      clr(); start();
      line = SJ; ones = 0; nst = 0;
      for (int i = 9; i >= 0; i--) begin
        if (!p[i]) line = 2'(3 - line);
        put(line);
        ones = p[i] ? ones + 1 : 0;
        if (ones == 6) begin
          line = 2'(3 - line); put(line); nst++; ones = 0;
        end
      end
      put(S0); put(S0); put(SJ);
      chk(nb == 10 && word[9:0] == p[9:0], "R1 decoded pattern", int'(word[9:0]), p);
      chk(n_drop == nst && n_err == 0 && n_eop == 1 && n_gap == 0, "R3 stuff drops and eop",
          n_drop * 100 + n_err * 10 + n_eop, nst * 100 + 1);
    end

    // R4 R5: seven equal J's give six ones then an error, then lock
    clr(); start();
    for (int i = 0; i < 7; i++) put(SJ);
    chk(nb == 6 && word[5:0] == 6'h3f && n_err == 1, "R4 error after six ones", nb * 10 + n_err, 61);
    put(SK); put(SJ); put(SJ);
    chk(nb == 6 && n_drop == 0 && n_err == 1, "R5 locked after error", nb * 10 + n_err, 61);
    put(S0); put(SJ);
    chk(n_eop == 1, "R5 eop after error", n_eop, 1);
    // R7: symbols after eop ignored
    put(SK); put(SJ); put(S0); put(SJ);
    chk(nb == 6 && n_eop == 1, "R7 idle after eop", nb * 10 + n_eop, 61);
    // R5: sop clears lock
    clr(); start(); put(SK);
    chk(nb == 1 && word[0] == 1'b0, "R5 sop clears lock", nb, 1);

    // R6: SE1 in data phase ignored, state kept
    clr(); start(); put(SK); put(S1); put(SK);
    chk(nb == 2 && word[1:0] == 2'b01, "R6 SE1 ignored", int'(word[1:0]), 1);
    // R6 R7: long SE0 then K, SE1 ignored, J closes
    put(S0); put(S0); put(S0); put(SK); put(S1);
    chk(nb == 2 && n_eop == 0, "R6 no bits during SE0", nb * 10 + n_eop, 20);
    put(SJ);
    chk(n_eop == 1 && n_gap == 0, "R7 single eop", n_eop, 1);

    // R2: mid-packet sop resets ones count
    clr(); start();
    for (int i = 0; i < 5; i++) put(SJ);
    start();
    for (int i = 0; i < 6; i++) put(SJ);
    put(SK);
    chk(n_drop == 1 && n_err == 0 && nb == 11, "R2 sop resets ones", n_drop * 10 + n_err, 10);

    // R9: sop beats same-cycle symbol
    clr();
    @(negedge clk); sop = 1'b1; sym_valid = 1'b1; sym = SK;
    @(posedge clk); #1; grab();
    gap();
    put(SJ);
    chk(nb == 1 && word[0] == 1'b1, "R9 sop wins", int'(word[0]), 1);

    // R8: no strobes in gap cycles across the tests
    chk(n_gap == 0, "R8 strobes single cycle", n_gap, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule